// File: doc/BRIEF.md
# Testable Conservative Universal Shift Register

This block is a four-stage universal shift register in which every steering and storage function is made from a single primitive: a controlled-swap cell with inputs (a, b, c) and outputs p = a, q = a ? c : b, r = a ? b : c. This cell conserves the number of ones from its inputs to its outputs. Each stage has a four-way selector built from three such cells, plus a storage element built from two cells around a clocked register. In normal operation the register holds, shifts towards the least significant bit, shifts towards the most significant bit, or loads a parallel word. The clock enable takes part in the swap network, so with the enable low every stage keeps its value.

Two test-control inputs, c1 and c2, drive the spare inputs of the second swap cell in each stage. With c1c2 = 01 the stage output follows the stored bit. With 00 or 11 every output line is forced to that uniform value. Because the cells conserve ones, an all-zeros vector on every data and control input leaves each internal line at 0, and an all-ones vector leaves each line at 1. A sequencer with five named states follows the test controls. It waits one settling cycle and then compares every observed internal and garbage line against the uniform value, which exposes a single stuck line without a scan chain. A fault-injection port can force any one of the sixteen named internal lines to a fixed value, so a bench can confirm detection.

Sequencer states: RUN (normal mode), PREP_Z and CHK_Z (zeros test), PREP_O and CHK_O (ones test). Transitions: c1c2 = 00 moves any state other than PREP_Z/CHK_Z to PREP_Z; PREP_Z or CHK_Z with 00 moves to CHK_Z; c1c2 = 11 moves any state other than PREP_O/CHK_O to PREP_O; PREP_O or CHK_O with 11 moves to CHK_O; c1c2 = 01 or 10 moves every state to RUN; reset moves to RUN.

Top module: `usr_cons_shreg`

## Requirements
- R1: A synchronous active-high reset clears all four stored bits and the fault flag at the clock edge, and it takes priority over every mode.
- R2: With c1c2 = 01, en = 1 and mode = 11, q_out equals par_in after the next rising edge.
- R3: With c1c2 = 01, en = 1 and mode = 00, the stored word is unchanged across the edge.
- R4: With c1c2 = 01, en = 1 and mode = 01 (shift right), the next word is {ser_r, q[3:1]}; bit 3 fills from ser_r.
- R5: With c1c2 = 01, en = 1 and mode = 10 (shift left), the next word is {q[2:0], ser_l}; bit 0 fills from ser_l.
- R6: With en = 0, the stored word is unchanged whatever mode and par_in are.
- R7: With c1c2 = 11, q_out is all ones at once. With the all-ones vector (en = 1, mode = 11, par_in = 1111, both serial inputs 1), a fault-free register keeps the flag low, and a later switch to c1c2 = 01 shows that 1111 was loaded.
- R8: With c1c2 = 00, q_out is all zeros. After reset with the all-zeros vector, the flag of a fault-free register stays low.
- R9: With c1c2 = 10, q_out is the bitwise complement of the stored word.
- R10: In test mode the sequencer spends one cycle in PREP and then compares in CHK. The flag is registered: it rises at the edge after the first CHK cycle that sees a deviating line, and it falls within two edges of a return to c1c2 = 01.
- R11: Injected line index 4*i + k selects stage i (0 to 3), with k = 0 the selector output, 1 the next-state line, 2 the stored line and 3 the stage output. A stuck-at-1 on any index is flagged under the zeros test, and a stuck-at-0 on any index is flagged under the ones test. A stuck value equal to the test value is not flagged.
- R12: While c1c2 stays 01 (state RUN), the flag stays low even when a fault is injected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Stage enable; low holds every stage |
| mode | input | 2 | Operation select: 00 hold, 01 right, 10 left, 11 load |
| par_in | input | 4 | Parallel load word |
| ser_l | input | 1 | Serial input entering bit 0 on shift left |
| ser_r | input | 1 | Serial input entering bit 3 on shift right |
| tc | input | 2 | Test controls {c1, c2}: 01 normal, 00 zeros test, 11 ones test, 10 inverted view |
| inj_en | input | 1 | Fault injection enable (simulation aid) |
| inj_line | input | 4 | Index of the line to force |
| inj_val | input | 1 | Value forced onto the selected line |
| q_out | output | 4 | Register output through the test-control cells |
| fault_flag | output | 1 | Registered stuck-line detection flag |

## Verification
The properties for normal operation assume that no fault is injected and that tc stays 01 across the edge they look at. Each of them names these conditions in its antecedent, so the bench phases with injection or with test controls never trigger them. The test-mode properties on q_out also require inj_en low. The bench drives the test vectors as whole uniform words and keeps them steady for several cycles before it samples the flag, so the settling cycle is always over before the flag is read.

// File: rtl/usr_pkg.sv
package usr_pkg;

    localparam int LINES_PER_STAGE = 4;
    localparam int OBS_PER_STAGE   = 9;
    localparam int OBS_TAIL        = 3;

    localparam int LN_SEL  = 0;
    localparam int LN_NEXT = 1;
    localparam int LN_STOR = 2;
    localparam int LN_OUT  = 3;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_PREP_Z = 3'd1,
        ST_CHK_Z  = 3'd2,
        ST_PREP_O = 3'd3,
        ST_CHK_O  = 3'd4
    } tst_state_e;

endpackage

// File: rtl/usr_swap_cell.sv
module usr_swap_cell (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    // Controlled swap: a passes through, b and c trade places when a is high.
    assign p = a;
    assign q = (~a & b) ^ (a & c);
    assign r = (~a & c) ^ (a & b);
endmodule

// File: rtl/usr_stuck_pt.sv
module usr_stuck_pt #(
    parameter int LW  = 4,
    parameter int IDX = 0
) (
    input  logic          i,
    input  logic          inj_en,
    input  logic [LW-1:0] inj_line,
    input  logic          inj_val,
    output logic          o
);
    localparam logic [LW-1:0] MY_IDX = LW'(IDX);

    assign o = (inj_en && (inj_line == MY_IDX)) ? inj_val : i;
endmodule

// File: rtl/usr_sel4.sv
module usr_sel4 (
    input  logic       s0,
    input  logic       s1,
    input  logic       in0,
    input  logic       in1,
    input  logic       in2,
    input  logic       in3,
    output logic       s0_o,
    output logic       s1_o,
    output logic       d,
    output logic [2:0] g
);
    logic s0_mid;
    logic m01;
    logic m23;

    // The select lines fan out only through the pass output of each cell.
    usr_swap_cell u_lo (.a(s0),     .b(in0), .c(in1), .p(s0_mid), .q(m01), .r(g[0]));
    usr_swap_cell u_hi (.a(s0_mid), .b(in2), .c(in3), .p(s0_o),   .q(m23), .r(g[1]));
    usr_swap_cell u_top(.a(s1),     .b(m01), .c(m23), .p(s1_o),   .q(d),   .r(g[2]));
endmodule

// File: rtl/usr_stage.sv
module usr_stage
    import usr_pkg::*;
#(
    parameter int LW   = 4,
    parameter int BASE = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_i,
    input  logic                     s0_i,
    input  logic                     s1_i,
    input  logic                     c1,
    input  logic                     c2,
    input  logic                     rin,
    input  logic                     lin,
    input  logic                     pin,
    input  logic                     inj_en,
    input  logic [LW-1:0]            inj_line,
    input  logic                     inj_val,
    output logic                     en_o,
    output logic                     s0_o,
    output logic                     s1_o,
    output logic                     q_st,
    output logic                     q_o,
    output logic [OBS_PER_STAGE-1:0] obs
);
    logic [2:0] sel_g;
    logic       d_raw;
    logic       d_f;
    logic       qn_raw;
    logic       qn_f;
    logic       g1;
    logic       qreg;
    logic       q_tap;
    logic       out_raw;
    logic       g2;

    usr_sel4 u_sel (
        .s0(s0_i), .s1(s1_i),
        .in0(q_st), .in1(rin), .in2(lin), .in3(pin),
        .s0_o(s0_o), .s1_o(s1_o), .d(d_raw), .g(sel_g)
    );

    usr_stuck_pt #(.LW(LW), .IDX(BASE + LN_SEL)) u_f_sel (
        .i(d_raw), .inj_en(inj_en), .inj_line(inj_line), .inj_val(inj_val), .o(d_f)
    );

    // First storage cell: enable chooses between new data and the held bit.
    usr_swap_cell u_st1 (.a(en_i), .b(q_st), .c(d_f), .p(en_o), .q(qn_raw), .r(g1));

    usr_stuck_pt #(.LW(LW), .IDX(BASE + LN_NEXT)) u_f_next (
        .i(qn_raw), .inj_en(inj_en), .inj_line(inj_line), .inj_val(inj_val), .o(qn_f)
    );

    always_ff @(posedge clk) begin
        if (rst) qreg <= 1'b0;
        else     qreg <= qn_f;
    end

    usr_stuck_pt #(.LW(LW), .IDX(BASE + LN_STOR)) u_f_stor (
        .i(qreg), .inj_en(inj_en), .inj_line(inj_line), .inj_val(inj_val), .o(q_st)
    );

    // Second storage cell: the test controls on the spare inputs.
    usr_swap_cell u_st2 (.a(q_st), .b(c1), .c(c2), .p(q_tap), .q(out_raw), .r(g2));

    usr_stuck_pt #(.LW(LW), .IDX(BASE + LN_OUT)) u_f_out (
        .i(out_raw), .inj_en(inj_en), .inj_line(inj_line), .inj_val(inj_val), .o(q_o)
    );

    assign obs = {g2, q_o, q_tap, g1, qn_f, d_f, sel_g};
endmodule

// File: rtl/usr_test_ctl.sv
module usr_test_ctl
    import usr_pkg::*;
#(
    parameter int NOBS = 39
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            c1,
    input  logic            c2,
    input  logic [NOBS-1:0] obs,
    output logic            fault_flag
);
    tst_state_e state;
    tst_state_e state_nx;
    logic       any_one;
    logic       any_zero;

    assign any_one  = |obs;
    assign any_zero = ~&obs;

    always_comb begin
        state_nx = ST_RUN;
        unique case ({c1, c2})
            2'b00: state_nx = (state == ST_PREP_Z || state == ST_CHK_Z) ? ST_CHK_Z : ST_PREP_Z;
            2'b11: state_nx = (state == ST_PREP_O || state == ST_CHK_O) ? ST_CHK_O : ST_PREP_O;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_flag <= 1'b0;
        end else begin
            unique case (state)
                ST_CHK_Z: fault_flag <= any_one;
                ST_CHK_O: fault_flag <= any_zero;
                ST_RUN, ST_PREP_Z, ST_PREP_O: fault_flag <= 1'b0;
                default: fault_flag <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/usr_cons_shreg.sv
module usr_cons_shreg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int LW    = $clog2(LINES_PER_STAGE * WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_l,
    input  logic             ser_r,
    input  logic [1:0]       tc,
    input  logic             inj_en,
    input  logic [LW-1:0]    inj_line,
    input  logic             inj_val,
    output logic [WIDTH-1:0] q_out,
    output logic             fault_flag
);
    localparam int NOBS = OBS_PER_STAGE * WIDTH + OBS_TAIL;

    logic [WIDTH:0]     en_ch;
    logic [WIDTH:0]     s0_ch;
    logic [WIDTH:0]     s1_ch;
    logic [WIDTH-1:0]   q_st;
    logic [NOBS-1:0]    obs;

    assign en_ch[0] = en;
    assign s0_ch[0] = mode[0];
    assign s1_ch[0] = mode[1];

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic rin;
        logic lin;

        if (i == WIDTH - 1) begin : g_rtop
            assign rin = ser_r;
        end else begin : g_rmid
            assign rin = q_st[i+1];
        end

        if (i == 0) begin : g_lbot
            assign lin = ser_l;
        end else begin : g_lmid
            assign lin = q_st[i-1];
        end

        usr_stage #(.LW(LW), .BASE(LINES_PER_STAGE * i)) u_stg (
            .clk(clk), .rst(rst),
            .en_i(en_ch[i]), .s0_i(s0_ch[i]), .s1_i(s1_ch[i]),
            .c1(tc[1]), .c2(tc[0]),
            .rin(rin), .lin(lin), .pin(par_in[i]),
            .inj_en(inj_en), .inj_line(inj_line), .inj_val(inj_val),
            .en_o(en_ch[i+1]), .s0_o(s0_ch[i+1]), .s1_o(s1_ch[i+1]),
            .q_st(q_st[i]), .q_o(q_out[i]),
            .obs(obs[OBS_PER_STAGE*i +: OBS_PER_STAGE])
        );
    end

    assign obs[NOBS-1 -: OBS_TAIL] = {en_ch[WIDTH], s0_ch[WIDTH], s1_ch[WIDTH]};

    usr_test_ctl #(.NOBS(NOBS)) u_ctl (
        .clk(clk), .rst(rst), .c1(tc[1]), .c2(tc[0]),
        .obs(obs), .fault_flag(fault_flag)
    );
endmodule

// File: rtl/usr_cons_shreg_chk.sv
module usr_cons_shreg_chk #(
    parameter int WIDTH = 4,
    parameter int LW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_l,
    input logic             ser_r,
    input logic [1:0]       tc,
    input logic             inj_en,
    input logic [LW-1:0]    inj_line,
    input logic             inj_val,
    input logic [WIDTH-1:0] q_out,
    input logic             fault_flag
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && tc == 2'b01 && !inj_en |-> q_out == '0 && !fault_flag); // R1

    AST_PAR_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(en && mode == 2'b11 && tc == 2'b01 && !inj_en && !rst) && tc == 2'b01 && !inj_en
        |-> q_out == $past(par_in)); // R2

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(en && mode == 2'b00 && tc == 2'b01 && !inj_en && !rst) && tc == 2'b01 && !inj_en
        |-> q_out == $past(q_out)); // R3

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        $past(en && mode == 2'b01 && tc == 2'b01 && !inj_en && !rst) && tc == 2'b01 && !inj_en
        |-> q_out == {$past(ser_r), $past(q_out[WIDTH-1:1])}); // R4

    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
        $past(en && mode == 2'b10 && tc == 2'b01 && !inj_en && !rst) && tc == 2'b01 && !inj_en
        |-> q_out == {$past(q_out[WIDTH-2:0]), $past(ser_l)}); // R5

    AST_EN_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(!en && tc == 2'b01 && !inj_en && !rst) && tc == 2'b01 && !inj_en
        |-> q_out == $past(q_out)); // R6

    AST_FORCE_ONES: assert property (@(posedge clk) disable iff (rst)
        tc == 2'b11 && !inj_en |-> &q_out); // R7

    AST_FORCE_ZEROS: assert property (@(posedge clk) disable iff (rst)
        tc == 2'b00 && !inj_en |-> q_out == '0); // R8

    AST_INVERT_VIEW: assert property (@(posedge clk) disable iff (rst)
        $past(!en && tc == 2'b01 && !inj_en && !rst) && tc == 2'b10 && !inj_en
        |-> q_out == ~$past(q_out)); // R9

    AST_RUN_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(tc == 2'b01) && $past(tc == 2'b01, 2) |-> !fault_flag); // R12
endmodule

bind usr_cons_shreg usr_cons_shreg_chk #(.WIDTH(WIDTH), .LW(LW)) u_chk (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .par_in(par_in),
    .ser_l(ser_l), .ser_r(ser_r), .tc(tc), .inj_en(inj_en),
    .inj_line(inj_line), .inj_val(inj_val), .q_out(q_out), .fault_flag(fault_flag)
);

// File: tb/sim_usr_cons_shreg.sv
`timescale 1ns/1ps
module sim_usr_cons_shreg;
    localparam int W  = 4;
    localparam int LW = 4;
    localparam int NV = 12;

    // {rst, en, mode[1:0], par[3:0], ser_l, ser_r, expected[3:0]}
    localparam logic [13:0] VEC [NV] = '{
        14'b0_1_11_1010_0_0_1010,
        14'b0_1_00_0000_0_0_1010,
        14'b0_1_01_0000_0_1_1101,
        14'b0_1_01_0000_0_0_0110,
        14'b0_1_10_0000_1_0_1101,
        14'b0_1_10_0000_0_0_1010,
        14'b0_0_11_0101_0_0_1010,
        14'b0_0_01_0000_0_1_1010,
        14'b0_1_11_0011_0_0_0011,
        14'b0_1_10_0000_1_0_0111,
        14'b0_1_01_0000_0_0_0011,
        14'b1_1_11_1111_0_0_0000
    };

    logic          clk = 1'b0;
    logic          rst, en, ser_l, ser_r, inj_en, inj_val;
    logic [1:0]    mode, tc;
    logic [W-1:0]  par_in;
    logic [LW-1:0] inj_line;
    logic [W-1:0]  q_out;
    logic          fault_flag;
    int            n_chk  = 0;
    int            n_fail = 0;

    always #2 clk = ~clk;

    usr_cons_shreg #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .par_in(par_in),
        .ser_l(ser_l), .ser_r(ser_r), .tc(tc), .inj_en(inj_en),
        .inj_line(inj_line), .inj_val(inj_val), .q_out(q_out), .fault_flag(fault_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_uniform(input logic v, input logic [1:0] t);
        en = v; mode = {v, v}; par_in = {W{v}}; ser_l = v; ser_r = v; tc = t;
    endtask

    task automatic do_reset();
        inj_en = 1'b0; rst = 1'b1; tc = 2'b01;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; mode = 2'b00; par_in = '0; ser_l = 1'b0; ser_r = 1'b0;
        tc = 2'b01; inj_en = 1'b0; inj_line = '0; inj_val = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset q", 32'(q_out), 32'h0);
        check("R1 reset flag", 32'(fault_flag), 32'h0);

        for (int k = 0; k < NV; k++) begin
            string tag;
            rst = VEC[k][13]; en = VEC[k][12]; mode = VEC[k][11:10];
            par_in = VEC[k][9:6]; ser_l = VEC[k][5]; ser_r = VEC[k][4];
            if (VEC[k][13])               tag = "R1";
            else if (!VEC[k][12])         tag = "R6";
            else if (mode == 2'b11)       tag = "R2";
            else if (mode == 2'b00)       tag = "R3";
            else if (mode == 2'b01)       tag = "R4";
            else                          tag = "R5";
            @(negedge clk);
            check(tag, 32'(q_out), 32'(VEC[k][3:0]));
        end
        rst = 1'b0;

        // R9: complement view
        en = 1'b1; mode = 2'b11; par_in = 4'b0011;
        @(negedge clk);
        en = 1'b0; tc = 2'b10; #1;
        check("R9 invert", 32'(q_out), 32'hC);
        tc = 2'b01;

        // R12: fault present in normal mode stays unflagged
        inj_en = 1'b1; inj_line = 4'd2; inj_val = 1'b1;
        repeat (4) @(negedge clk);
        check("R12 run quiet", 32'(fault_flag), 32'h0);
        inj_en = 1'b0;

        // R8: zeros test on a fault-free register
        do_reset();
        drive_uniform(1'b0, 2'b00); #1;
        check("R8 forced zeros", 32'(q_out), 32'h0);
        repeat (4) @(negedge clk);
        check("R8 zeros flag", 32'(fault_flag), 32'h0);

        // R10: flag timing from RUN through PREP_Z and CHK_Z
        tc = 2'b01;
        repeat (2) @(negedge clk);
        drive_uniform(1'b0, 2'b00);
        inj_en = 1'b1; inj_line = 4'd5; inj_val = 1'b1;
        @(negedge clk);
        check("R10 prep low", 32'(fault_flag), 32'h0);
        @(negedge clk);
        check("R10 chk first cycle low", 32'(fault_flag), 32'h0);
        @(negedge clk);
        check("R10 flag rises", 32'(fault_flag), 32'h1);
        inj_en = 1'b0; tc = 2'b01;
        repeat (2) @(negedge clk);
        check("R10 flag clears", 32'(fault_flag), 32'h0);

        // R7: ones test on a fault-free register
        do_reset();
        drive_uniform(1'b1, 2'b11); #1;
        check("R7 forced ones", 32'(q_out), 32'hF);
        repeat (4) @(negedge clk);
        check("R7 ones flag", 32'(fault_flag), 32'h0);
        tc = 2'b01; #1;
        check("R7 load completed", 32'(q_out), 32'hF);

        // R11: every line, both polarities
        for (int ln = 0; ln < 4 * W; ln++) begin
            do_reset();
            drive_uniform(1'b0, 2'b00);
            inj_en = 1'b1; inj_line = LW'(ln); inj_val = 1'b1;
            repeat (4) @(negedge clk);
            check($sformatf("R11 sa1 line %0d", ln), 32'(fault_flag), 32'h1);
            drive_uniform(1'b1, 2'b11);
            inj_val = 1'b0;
            repeat (4) @(negedge clk);
            check($sformatf("R11 sa0 line %0d", ln), 32'(fault_flag), 32'h1);
        end

        // R11: stuck value equal to the test value goes unseen
        do_reset();
        drive_uniform(1'b0, 2'b00);
        inj_en = 1'b1; inj_line = 4'd6; inj_val = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 same polarity", 32'(fault_flag), 32'h0);
        inj_en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule